// File: doc/BRIEF.md
# Two-Input Queued Stream Merge

This block joins two independent message streams into a single output stream. Each source side has a valid/ready handshake and its own small circular queue. A message is taken only while that side's queue has space. The output side presents a message whenever either queue holds one. When both queues hold data, a round-robin choice decides which queue is served, so neither source can starve the other. Messages from one source leave in the order they arrived. Messages from the two sources interleave in an order set by arrival and by the round-robin choice.

The block takes exactly one action per clock: one enqueue on side A, one enqueue on side B, or one dequeue to the output. A dequeue takes precedence. When both sources offer at once, an enqueue turn pointer alternates between them. Because the output is an ordinary valid/ready source, one merge can drive a source side of a second merge, which gives a three-input merge.

Top module: `dual_queue_merge`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) empties both queues and points both the enqueue turn and the output preference at side A. After reset, `m_valid` is 0, and `a_ready` and `b_ready` are 1 while no output transfer is possible.
- R2: A side's ready is 0 while its queue holds DEPTH messages. A message offered on that side is then not accepted and never appears at the output.
- R3: `m_valid` is 1 exactly when at least one queue is non-empty, and `m_data` is the oldest message of the queue being served.
- R4: At most one of the four actions (enqueue A, enqueue B, dequeue A, dequeue B) happens per cycle. While `m_valid` and `m_ready` are both 1, `a_ready` and `b_ready` are both 0.
- R5: When both sides are valid, both queues have room and no dequeue happens, only the side holding the enqueue turn is ready. The turn starts at A after reset and moves to the other side after every enqueue.
- R6: When both queues are non-empty, the output serves the queue other than the one dequeued last. After reset, side A is preferred.
- R7: While `m_valid` is 1 and `m_ready` is 0, the next cycle keeps `m_valid` at 1 and `m_data` unchanged, even if the other queue receives a message.
- R8: The messages accepted on each side leave through the output in their order of acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_valid | input | 1 | Side A offers a message |
| a_data | input | WIDTH | Side A message |
| a_ready | output | 1 | Side A message is taken this cycle if valid |
| b_valid | input | 1 | Side B offers a message |
| b_data | input | WIDTH | Side B message |
| b_ready | output | 1 | Side B message is taken this cycle if valid |
| m_valid | output | 1 | A merged message is presented |
| m_data | output | WIDTH | Merged message |
| m_ready | input | 1 | Downstream takes the presented message |

## Verification
The hardest situation to reach is a stalled output on one queue while the other queue turns non-empty, because that is the only time the round-robin preference could switch the presented message. The stimulus fills both queues with the output held off, stalls the output on a single queue and then offers only the other side, and after that drains with `m_ready` high so that each queue full, each queue empty and every alternation of the output choice occurs. A reference model in the bench follows both queues, the turn and the preference each cycle, and predicts every ready, valid and data value.

// File: rtl/dqm_pkg.sv
package dqm_pkg;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  // choose the queue to serve: preference only matters when both hold data
  function automatic src_e pick_src(input logic a_ne, input logic b_ne, input src_e pref);
    if (a_ne && b_ne) return pref;
    return a_ne ? SRC_A : SRC_B;
  endfunction

  function automatic src_e other_src(input src_e s);
    return (s == SRC_A) ? SRC_B : SRC_A;
  endfunction

endpackage

// File: rtl/dqm_ring.sv
module dqm_ring #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW:0]      wr_ptr, rd_ptr;
  logic [WIDTH-1:0] store [DEPTH];

  // pointers carry one wrap bit above the index
  function automatic logic ptr_full(input logic [AW:0] w, input logic [AW:0] r);
    return (w[AW] != r[AW]) && (w[AW-1:0] == r[AW-1:0]);
  endfunction

  function automatic logic ptr_empty(input logic [AW:0] w, input logic [AW:0] r);
    return w == r;
  endfunction

  assign full  = ptr_full(wr_ptr, rd_ptr);
  assign empty = ptr_empty(wr_ptr, rd_ptr);
  assign head  = store[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr[AW-1:0]] <= din;
  end

  // R2
  push_full_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full)
    else $error("push into full queue");

  // R3
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
    else $error("pop from empty queue");

endmodule

// File: rtl/dqm_arbiter.sv
module dqm_arbiter
  import dqm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_valid,
  input  logic b_valid,
  input  logic a_full,
  input  logic b_full,
  input  logic a_empty,
  input  logic b_empty,
  input  logic m_ready,
  output logic a_ready,
  output logic b_ready,
  output logic push_a,
  output logic push_b,
  output logic pop_a,
  output logic pop_b,
  output logic m_valid,
  output src_e sel
);
  src_e turn;   // which side wins an enqueue tie
  src_e pref;   // which queue is preferred at the output
  logic deq;

  assign m_valid = !a_empty || !b_empty;
  assign sel     = pick_src(!a_empty, !b_empty, pref);
  assign deq     = m_valid && m_ready;
  assign pop_a   = deq && (sel == SRC_A);
  assign pop_b   = deq && (sel == SRC_B);

  // a dequeue takes the single action slot of the cycle
  assign a_ready = !a_full && !deq && (!b_valid || b_full || turn == SRC_A);
  assign b_ready = !b_full && !deq && (!a_valid || a_full || turn == SRC_B);
  assign push_a  = a_valid && a_ready;
  assign push_b  = b_valid && b_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      turn <= SRC_A;
      pref <= SRC_A;
    end else begin
      if (push_a)      turn <= SRC_B;
      else if (push_b) turn <= SRC_A;
      if (deq)          pref <= other_src(sel);
      else if (m_valid) pref <= sel;   // lock the presented queue during a stall
    end
  end

  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({push_a, push_b, pop_a, pop_b}) <= 1)
    else $error("more than one action in a cycle");

  // R5
  tie_single_chk: assert property (@(posedge clk) disable iff (rst)
    (a_valid && b_valid && !a_full && !b_full && !m_valid) |-> (push_a != push_b))
    else $error("enqueue tie not resolved to one side");

  // R6
  rr_after_a_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_a && !b_empty) |=> (sel == SRC_B))
    else $error("queue B not served after A");

  // R6
  rr_after_b_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_b && !a_empty) |=> (sel == SRC_A))
    else $error("queue A not served after B");

  // R7
  stall_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && sel == $past(sel)))
    else $error("output choice moved during stall");

  // R3
  valid_head_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> ((sel == SRC_A) ? !a_empty : !b_empty))
    else $error("served queue is empty");

endmodule

// File: rtl/dual_queue_merge.sv
module dual_queue_merge
  import dqm_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [WIDTH-1:0] a_data,
  output logic             a_ready,
  input  logic             b_valid,
  input  logic [WIDTH-1:0] b_data,
  output logic             b_ready,
  output logic             m_valid,
  output logic [WIDTH-1:0] m_data,
  input  logic             m_ready
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] q_push, q_pop, q_full, q_empty;
  logic [WIDTH-1:0] q_din  [NSRC];
  logic [WIDTH-1:0] q_head [NSRC];
  src_e            sel;

  assign q_din[0] = a_data;
  assign q_din[1] = b_data;

  for (genvar i = 0; i < NSRC; i++) begin : g_queue
    dqm_ring #(.WIDTH(WIDTH), .DEPTH(DEPTH)) ring_i (
      .clk  (clk),
      .rst  (rst),
      .push (q_push[i]),
      .din  (q_din[i]),
      .pop  (q_pop[i]),
      .head (q_head[i]),
      .full (q_full[i]),
      .empty(q_empty[i])
    );
  end

  dqm_arbiter arb_i (
    .clk    (clk),
    .rst    (rst),
    .a_valid(a_valid),
    .b_valid(b_valid),
    .a_full (q_full[0]),
    .b_full (q_full[1]),
    .a_empty(q_empty[0]),
    .b_empty(q_empty[1]),
    .m_ready(m_ready),
    .a_ready(a_ready),
    .b_ready(b_ready),
    .push_a (q_push[0]),
    .push_b (q_push[1]),
    .pop_a  (q_pop[0]),
    .pop_b  (q_pop[1]),
    .m_valid(m_valid),
    .sel    (sel)
  );

  assign m_data = (sel == SRC_B) ? q_head[1] : q_head[0];

  // R7
  stall_data_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)))
    else $error("output data changed during stall");

  // R1
  reset_empty_chk: assert property (@(posedge clk) rst |=> !m_valid)
    else $error("output valid right after reset");

endmodule

// File: tb/dual_queue_merge_tb_top.sv
module dual_queue_merge_tb_top;
  localparam int W = 8;
  localparam int D = 4;
  localparam int NSEG = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_valid = 1'b0, b_valid = 1'b0, m_ready = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, m_valid;
  logic [W-1:0] m_data;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // reference state
  int qa[$];
  int qb[$];
  bit m_turn;   // 0: side A wins tie
  bit m_pref;   // 0: queue A preferred
  logic [W-1:0] last_data;

  always #5 clk = ~clk;

  dual_queue_merge #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
    .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  // segment table: {a_valid, b_valid, m_ready} held for SEG_LEN cycles
  localparam logic [2:0] SEG_PAT [NSEG] = '{
    3'b110, 3'b100, 3'b001, 3'b100, 3'b000, 3'b010, 3'b001,
    3'b111, 3'b101, 3'b011, 3'b110, 3'b011, 3'b001, 3'b000
  };
  localparam int SEG_LEN [NSEG] = '{10, 2, 10, 1, 1, 2, 4, 6, 6, 6, 5, 4, 8, 2};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    qa.delete();
    qb.delete();
    m_turn = 1'b0;
    m_pref = 1'b0;
  endtask

  task automatic step(input bit av, input logic [W-1:0] ad, input bit bv,
                      input logic [W-1:0] bd, input bit mr);
    bit ev, esel, deq, ra, rb;
    int ed;
    @(negedge clk);
    a_valid = av; a_data = ad;
    b_valid = bv; b_data = bd;
    m_ready = mr;
    #2;
    ev   = (qa.size() > 0) || (qb.size() > 0);
    esel = (qa.size() > 0 && qb.size() > 0) ? m_pref : (qa.size() == 0);
    ed   = ev ? (esel ? qb[0] : qa[0]) : 0;
    deq  = ev && mr;
    ra   = (qa.size() < D) && !deq && (!bv || qb.size() == D || !m_turn);
    rb   = (qb.size() < D) && !deq && (!av || qa.size() == D || m_turn);
    check("R3 m_valid", int'(m_valid), int'(ev));
    if (ev) check("R3 R6 R8 m_data", int'(m_data), ed);
    check("R2 R4 R5 a_ready", int'(a_ready), int'(ra));
    check("R2 R4 R5 b_ready", int'(b_ready), int'(rb));
    // next reference state
    if (deq) begin
      if (esel) void'(qb.pop_front()); else void'(qa.pop_front());
      m_pref = !esel;
    end else if (ev) begin
      m_pref = esel;
    end
    if (av && ra) begin qa.push_back(int'(ad)); m_turn = 1'b1; end
    else if (bv && rb) begin qb.push_back(int'(bd)); m_turn = 1'b0; end
    last_data = m_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_valid = 0; b_valid = 0; m_ready = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    #2;
    // R1 reset state at the ports
    check("R1 m_valid", int'(m_valid), 0);
    check("R1 a_ready", int'(a_ready), 1);
    check("R1 b_ready", int'(b_ready), 1);
  endtask

  initial begin
    int idx = 0;
    model_clear();
    do_reset();

    // table walk; first entry checks R5 tie going to A after reset
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < SEG_LEN[s]; c++) begin
        step(SEG_PAT[s][2], W'(8'h10 + idx), SEG_PAT[s][1], W'(8'h80 + idx), SEG_PAT[s][0]);
        idx++;
      end
    end

    // R2: fill A while output is held, extra offers rejected
    for (int k = 0; k < D + 2; k++) step(1'b1, W'(8'h40 + k), 1'b0, '0, 1'b0);
    check("R2 a_ready when full", int'(a_ready), 0);

    // R1: reset with data held clears everything
    do_reset();

    // R7: stall on A, then B becomes non-empty; presented data must hold
    step(1'b1, 8'hA5, 1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b1, 8'h5A, 1'b0);
    check("R7 hold after B arrives", int'(last_data), 32'hA5);
    step(1'b0, '0, 1'b0, '0, 1'b0);
    check("R7 hold next cycle", int'(last_data), 32'hA5);
    // R6: serve A then B
    step(1'b0, '0, 1'b0, '0, 1'b1);
    check("R6 first served", int'(last_data), 32'hA5);
    step(1'b0, '0, 1'b0, '0, 1'b1);
    check("R6 second served", int'(last_data), 32'h5A);
    step(1'b0, '0, 1'b0, '0, 1'b1);
    check("R3 empty after drain", int'(m_valid), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule